// File: doc/BRIEF.md
# Serial-Clocked Wiper Up/Down Stepper

This block moves a potentiometer wiper position one tap at a time while a serial host clocks the bus. Once the serial front end has acknowledged the increment/decrement instruction, the block enters stepping mode. In that mode each qualified serial-clock pulse moves the wiper by one tap. The level of the data line, sampled on the rising edge of that pulse, sets the direction: high steps toward the high terminal and low steps toward the low terminal.

Stepping continues until the front end reports a start or a stop condition. The block holds the wiper position register, which other instructions can overwrite through a load port. It never drives the data line.

Each step is taken at the falling edge of the pulse, not at the rising edge. A start or stop condition always occurs while the clock is high, so a pulse that carries one of these conditions is cancelled and produces no step.

Top module: `wiper_stepper`

## Requirements
- R1: After a synchronous active-low reset the wiper position is 0 and stepping mode is inactive (`stepping_o` = 0).
- R2: Stepping mode is entered only through an `incdec_ack_i` pulse. `stepping_o` reads 1 from the cycle after that pulse. Serial-clock pulses received while the mode is inactive leave the wiper unchanged.
- R3: In stepping mode, a pulse with `sda_i` = 1 at its `scl_rise_i` cycle raises the wiper by exactly one. The new value is visible in the cycle after the `scl_fall_i` cycle.
- R4: In stepping mode, a pulse with `sda_i` = 0 at its `scl_rise_i` cycle lowers the wiper by exactly one, with the same timing as R3.
- R5: The wiper saturates. An up step at 63 leaves it at 63, and a down step at 0 leaves it at 0. It never wraps.
- R6: `stop_i` ends stepping mode from the next cycle. A stop seen after a rising edge and no later than its falling edge cancels that pulse's step.
- R7: `start_i` ends stepping mode and cancels a pending step in the same way as `stop_i` (R6).
- R8: The direction is taken only from `sda_i` in the `scl_rise_i` cycle. A change of `sda_i` before the falling edge has no effect.
- R9: `wcr_wr_i` = 1 loads `wcr_wr_val_i` into the wiper, visible in the next cycle. The load wins over a step committed in the same cycle.
- R10: A falling edge with no rising edge since the mode was entered gives no step. A rising edge in the same cycle as `incdec_ack_i` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_rise_i | input | 1 | One-cycle pulse: qualified serial-clock rising edge |
| scl_fall_i | input | 1 | One-cycle pulse: qualified serial-clock falling edge |
| sda_i | input | 1 | Synchronised data-line level |
| start_i | input | 1 | One-cycle pulse: start condition detected |
| stop_i | input | 1 | One-cycle pulse: stop condition detected |
| incdec_ack_i | input | 1 | One-cycle pulse: increment/decrement instruction acknowledged |
| wcr_wr_i | input | 1 | Load strobe for the wiper register |
| wcr_wr_val_i | input | W (6) | Value to load into the wiper register |
| wiper_o | output | W (6) | Current wiper position |
| stepping_o | output | 1 | Stepping mode active |

## Verification
The hardest case to reach is a start or stop condition that falls between the rising and falling edge of a pulse. In that case a step has already been sampled but must not be committed. The stimulus drives a rising edge in stepping mode and then raises the condition before, and separately in the same cycle as, the falling edge. It then checks that the wiper did not move and that the mode dropped. The saturation limits are reached by loading values next to each end and then stepping past them. A behavioural model runs alongside and checks every cycle.

// File: rtl/wiper_step_pkg.sv
// Shared types for the wiper stepper.
// Assumes: used by all wiper stepper submodules; no state.
package wiper_step_pkg;
    typedef enum logic {
        STEP_DOWN = 1'b0,
        STEP_UP   = 1'b1
    } step_dir_e;
endpackage

// File: rtl/wstep_mode_ctl.sv
// Stepping-mode flag.
// Set by the acknowledged increment/decrement instruction and cleared by
// any bus start or stop event.
// Assumes: the event inputs are single-cycle pulses from the serial front end.
module wstep_mode_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic end_i,
    output logic active_o
);
    // Mode flag: an end event takes priority over arming.
    always_ff @(posedge clk) begin
        if (!rst_n)
            active_o <= 1'b0;
        else if (end_i)
            active_o <= 1'b0;
        else if (arm_i)
            active_o <= 1'b1;
    end
endmodule

// File: rtl/wstep_sampler.sv
// Per-pulse direction sampler.
// Captures the data level at a qualified rising edge and releases a commit
// at the matching falling edge. The pending step is dropped on arming or on
// a start/stop event.
// Assumes: rising and falling edge pulses alternate and never share a cycle.
module wstep_sampler
    import wiper_step_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      active_i,
    input  logic      arm_i,
    input  logic      end_i,
    input  logic      rise_i,
    input  logic      fall_i,
    input  logic      sda_i,
    output logic      commit_o,
    output step_dir_e dir_o
);
    logic      pend_q;
    step_dir_e dir_q;

    // Pending flag: armed by an in-mode rising edge, consumed by the falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= 1'b0;
        else if (end_i || arm_i)
            pend_q <= 1'b0;
        else if (rise_i && active_i)
            pend_q <= 1'b1;
        else if (fall_i)
            pend_q <= 1'b0;
    end

    // Direction register: data level latched only at the rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dir_q <= STEP_DOWN;
        else if (rise_i && active_i)
            dir_q <= sda_i ? STEP_UP : STEP_DOWN;
    end

    // Commit strobe: falling edge of a still-valid pending pulse.
    always_comb begin
        commit_o = pend_q && fall_i && active_i && !end_i;
        dir_o    = dir_q;
    end
endmodule

// File: rtl/wstep_counter.sv
// Saturating wiper position register.
// A load has priority over a committed step; a step at either end holds.
// Assumes: commit_i lasts a single cycle per pulse.
module wstep_counter
    import wiper_step_pkg::*;
#(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         commit_i,
    input  step_dir_e    dir_i,
    output logic [W-1:0] pos_o
);
    localparam logic [W-1:0] TOP = {W{1'b1}};
    localparam logic [W-1:0] BOT = '0;

    logic [W-1:0] next_step;

    // Saturated neighbour position in the requested direction.
    always_comb begin
        next_step = pos_o;
        if (dir_i == STEP_UP) begin
            if (pos_o != TOP)
                next_step = pos_o + 1'b1;
        end else begin
            if (pos_o != BOT)
                next_step = pos_o - 1'b1;
        end
    end

    // Position register: reset, load or step.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pos_o <= BOT;
        else if (load_i)
            pos_o <= load_val_i;
        else if (commit_i)
            pos_o <= next_step;
    end
endmodule

// File: rtl/wiper_stepper.sv
// Top of the serial-clocked wiper stepper.
// Joins the mode flag, the per-pulse sampler and the saturating position
// register. Never drives the data line.
// Assumes: all strobes are synchronous single-cycle pulses from the front end.
module wiper_stepper
    import wiper_step_pkg::*;
#(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         scl_rise_i,
    input  logic         scl_fall_i,
    input  logic         sda_i,
    input  logic         start_i,
    input  logic         stop_i,
    input  logic         incdec_ack_i,
    input  logic         wcr_wr_i,
    input  logic [W-1:0] wcr_wr_val_i,
    output logic [W-1:0] wiper_o,
    output logic         stepping_o
);
    logic      end_evt;
    logic      commit;
    step_dir_e dir;

    // Any bus framing event ends the stepping sequence.
    always_comb end_evt = start_i || stop_i;

    wstep_mode_ctl u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm_i    (incdec_ack_i),
        .end_i    (end_evt),
        .active_o (stepping_o)
    );

    wstep_sampler u_smp (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (stepping_o),
        .arm_i    (incdec_ack_i),
        .end_i    (end_evt),
        .rise_i   (scl_rise_i),
        .fall_i   (scl_fall_i),
        .sda_i    (sda_i),
        .commit_o (commit),
        .dir_o    (dir)
    );

    wstep_counter #(.W(W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (wcr_wr_i),
        .load_val_i (wcr_wr_val_i),
        .commit_i   (commit),
        .dir_i      (dir),
        .pos_o      (wiper_o)
    );
endmodule

// File: rtl/wiper_stepper_chk.sv
// Assertion checker for wiper_stepper, attached by bind.
// Assumes: observes only the top-level ports.
module wiper_stepper_chk #(
    parameter int W = 6
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start_i,
    input logic         stop_i,
    input logic         incdec_ack_i,
    input logic         wcr_wr_i,
    input logic [W-1:0] wcr_wr_val_i,
    input logic [W-1:0] wiper_o,
    input logic         stepping_o
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    // R2: arming without a framing event enters the mode.
    p_arm_enters_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (incdec_ack_i && !start_i && !stop_i) |=> stepping_o);

    // R2: outside the mode and without a load, the wiper holds.
    p_idle_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!stepping_o && !wcr_wr_i) |=> (wiper_o == $past(wiper_o)));

    // R3: without a load, a cycle moves the wiper by at most one tap.
    p_single_tap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wcr_wr_i |=> ((wiper_o == $past(wiper_o)) ||
                       (wiper_o == $past(wiper_o) + 1'b1) ||
                       (wiper_o == $past(wiper_o) - 1'b1)));

    // R5: no wrap from the top end.
    p_no_wrap_top_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wiper_o == TOP && !wcr_wr_i) |=> (wiper_o >= TOP - 1'b1));

    // R5: no wrap from the bottom end.
    p_no_wrap_bot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wiper_o == '0 && !wcr_wr_i) |=> (wiper_o <= 1));

    // R6: a stop ends the mode.
    p_stop_exits_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> !stepping_o);

    // R7: a start ends the mode.
    p_start_exits_r7: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> !stepping_o);

    // R9: a load sets the wiper to the loaded value.
    p_load_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wcr_wr_i |=> (wiper_o == $past(wcr_wr_val_i)));
endmodule

bind wiper_stepper wiper_stepper_chk #(.W(W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .stop_i       (stop_i),
    .incdec_ack_i (incdec_ack_i),
    .wcr_wr_i     (wcr_wr_i),
    .wcr_wr_val_i (wcr_wr_val_i),
    .wiper_o      (wiper_o),
    .stepping_o   (stepping_o)
);

// File: tb/sim_wiper_stepper.sv
module sim_wiper_stepper;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_rise_i = 1'b0, scl_fall_i = 1'b0, sda_i = 1'b0;
    logic       start_i = 1'b0, stop_i = 1'b0, incdec_ack_i = 1'b0;
    logic       wcr_wr_i = 1'b0;
    logic [5:0] wcr_wr_val_i = '0;
    logic [5:0] wiper_o;
    logic       stepping_o;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;
    string phase = "R1";

    // Behavioural reference state.
    int  m_pos = 0;
    bit  m_mode = 0;
    bit  m_pend = 0;
    bit  m_up = 0;

    always #2.5 clk = ~clk;

    wiper_stepper u0 (
        .clk(clk), .rst_n(rst_n), .scl_rise_i(scl_rise_i), .scl_fall_i(scl_fall_i),
        .sda_i(sda_i), .start_i(start_i), .stop_i(stop_i), .incdec_ack_i(incdec_ack_i),
        .wcr_wr_i(wcr_wr_i), .wcr_wr_val_i(wcr_wr_val_i),
        .wiper_o(wiper_o), .stepping_o(stepping_o)
    );

    // Reference model: evaluates the requirements on each rising clock edge.
    always @(posedge clk) begin
        bit ev;
        bit take;
        ev   = start_i || stop_i;
        take = m_mode && m_pend && scl_fall_i && !ev;
        if (!rst_n) begin
            m_pos = 0; m_mode = 0; m_pend = 0; m_up = 0;
        end else begin
            if (wcr_wr_i) m_pos = wcr_wr_val_i;
            else if (take) begin
                if (m_up) m_pos = (m_pos < 63) ? m_pos + 1 : 63;
                else      m_pos = (m_pos > 0) ? m_pos - 1 : 0;
            end
            if (ev || incdec_ack_i) m_pend = 0;
            else if (scl_rise_i && m_mode) begin m_pend = 1; m_up = sda_i; end
            else if (scl_fall_i) m_pend = 0;
            if (ev) m_mode = 0;
            else if (incdec_ack_i) m_mode = 1;
        end
    end

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            compared++;
            if (wiper_o !== 6'(m_pos) || stepping_o !== m_mode) begin
                mismatched++;
                $display("FAIL %s cycle compare: wiper=%0d stepping=%0b expected wiper=%0d stepping=%0b",
                         phase, wiper_o, stepping_o, m_pos, m_mode);
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            mismatched++;
            $display("FAIL watchdog expired: cycles=%0d expected below 20000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic strobe_arm;
        incdec_ack_i = 1'b1; @(negedge clk); incdec_ack_i = 1'b0; @(negedge clk);
    endtask

    task automatic strobe_stop;
        stop_i = 1'b1; @(negedge clk); stop_i = 1'b0; @(negedge clk);
    endtask

    task automatic strobe_start;
        start_i = 1'b1; @(negedge clk); start_i = 1'b0; @(negedge clk);
    endtask

    task automatic load(input int v);
        wcr_wr_i = 1'b1; wcr_wr_val_i = 6'(v); @(negedge clk);
        wcr_wr_i = 1'b0; @(negedge clk);
    endtask

    // One serial-clock pulse: data level at rise, optional different level at fall.
    task automatic pulse2(input bit d_rise, input bit d_fall);
        sda_i = d_rise; scl_rise_i = 1'b1; @(negedge clk);
        scl_rise_i = 1'b0; @(negedge clk);
        sda_i = d_fall; scl_fall_i = 1'b1; @(negedge clk);
        scl_fall_i = 1'b0; @(negedge clk);
    endtask

    task automatic pulse(input bit d);
        pulse2(d, d);
    endtask

    task automatic check(input string tag, input int exp_pos, input bit exp_act);
        compared++;
        if (wiper_o !== 6'(exp_pos) || stepping_o !== exp_act) begin
            mismatched++;
            $display("FAIL %s: wiper=%0d stepping=%0b expected wiper=%0d stepping=%0b",
                     tag, wiper_o, stepping_o, exp_pos, exp_act);
        end
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        check("R1 reset state", 0, 0);

        phase = "R2";
        pulse(1); pulse(1);
        check("R2 pulses ignored outside mode", 0, 0);
        load(30);
        check("R9 load", 30, 0);
        strobe_arm;
        check("R2 mode entered", 30, 1);

        phase = "R3";
        pulse(1); check("R3 single up step", 31, 1);
        pulse(1); pulse(1);
        check("R3 two more up steps", 33, 1);

        phase = "R4";
        pulse(0); pulse(0);
        check("R4 two down steps", 31, 1);

        phase = "R8";
        pulse2(1, 0);
        check("R8 direction from rise sample (up)", 32, 1);
        pulse2(0, 1);
        check("R8 direction from rise sample (down)", 31, 1);

        phase = "R6";
        strobe_stop;
        check("R6 stop ends mode", 31, 0);
        pulse(1);
        check("R6 no step after stop", 31, 0);
        strobe_arm;
        sda_i = 1'b1; scl_rise_i = 1'b1; @(negedge clk); scl_rise_i = 1'b0; @(negedge clk);
        strobe_stop;
        scl_fall_i = 1'b1; @(negedge clk); scl_fall_i = 1'b0; @(negedge clk);
        check("R6 stop between edges cancels step", 31, 0);
        strobe_arm;
        sda_i = 1'b1; scl_rise_i = 1'b1; @(negedge clk); scl_rise_i = 1'b0; @(negedge clk);
        scl_fall_i = 1'b1; stop_i = 1'b1; @(negedge clk);
        scl_fall_i = 1'b0; stop_i = 1'b0; @(negedge clk);
        check("R6 stop with falling edge cancels step", 31, 0);

        phase = "R7";
        strobe_arm;
        pulse(1);
        check("R7 step before start", 32, 1);
        sda_i = 1'b0; scl_rise_i = 1'b1; @(negedge clk); scl_rise_i = 1'b0; @(negedge clk);
        strobe_start;
        scl_fall_i = 1'b1; @(negedge clk); scl_fall_i = 1'b0; @(negedge clk);
        check("R7 start ends mode and cancels step", 32, 0);
        pulse(0);
        check("R7 no step after start", 32, 0);

        phase = "R5";
        load(61);
        strobe_arm;
        pulse(1); pulse(1); pulse(1); pulse(1);
        check("R5 saturate at 63", 63, 1);
        load(2);
        pulse(0); pulse(0); pulse(0); pulse(0);
        check("R5 saturate at 0", 0, 1);
        pulse(1);
        check("R5 up from 0", 1, 1);
        strobe_stop;

        phase = "R10";
        strobe_arm;
        scl_fall_i = 1'b1; @(negedge clk); scl_fall_i = 1'b0; @(negedge clk);
        check("R10 lone falling edge no step", 1, 1);
        strobe_stop;
        sda_i = 1'b1; scl_rise_i = 1'b1; incdec_ack_i = 1'b1; @(negedge clk);
        scl_rise_i = 1'b0; incdec_ack_i = 1'b0; @(negedge clk);
        scl_fall_i = 1'b1; @(negedge clk); scl_fall_i = 1'b0; @(negedge clk);
        check("R10 rise with arm ignored", 1, 1);

        phase = "R9";
        sda_i = 1'b1; scl_rise_i = 1'b1; @(negedge clk); scl_rise_i = 1'b0; @(negedge clk);
        scl_fall_i = 1'b1; wcr_wr_i = 1'b1; wcr_wr_val_i = 6'd10; @(negedge clk);
        scl_fall_i = 1'b0; wcr_wr_i = 1'b0; @(negedge clk);
        check("R9 load wins over step", 10, 1);
        pulse(1);
        check("R9 stepping resumes after load", 11, 1);
        strobe_stop;

        idle(2);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule